// File: doc/BRIEF.md
# Flow Table Insertion Controller

This block owns a small on-chip flow table and installs prepared flow entries into it. A caller hands over a header word, a payload and a timestamp together with a bucket index that has already been hashed. The controller looks at the header of that bucket and, when needed, of the slot right after it. It writes the entry into the first slot that is free to take it and returns the slot number, or reports that there is no space. Every entry takes one header word and `PAY_WORDS` payload words in a single-port RAM. The header holds the state in bits [1:0] (0 = INVALID, 1 = UNBIND, 2 = BIND, 3 = FIN), a static flag in bit 2 and an 8-bit timestamp in bits [10:3].

The controller also brings the table up and takes it down. Bring-up zeroes every word, can reserve seven fixed slots in each group of 128 entries, and then sets the engine-enable output. Take-down rewrites every header as INVALID, clears engine-enable and waits for the engine's busy input to fall, with a limit on how long it waits. A lookup port lets the forwarding engine read any table word whenever the controller is not using the RAM.

Top module: `flow_table_inserter`

## Requirements
- R1: After reset, engine_en, res_valid, cache_clr, init_done and stop_done are 0, and ins_ready is 1 while no init or stop request is present.
- R2: The header that gets written is the caller's header with bits [10:3] replaced by the low 8 bits of ins_ts. All other header bits pass through unchanged.
- R3: A slot is usable when its static bit (bit 2) is 0 and its state (bits [1:0]) is not BIND (2). The bucket slot is probed first and slot (bucket + 1) mod ENTRIES second. The first usable slot is written and returned in res_slot with res_ok = 1.
- R4: If neither probed slot is usable, res_valid comes with res_ok = 0 and no table word changes.
- R5: Entry word 0 holds the header and words 1..PAY_WORDS hold payload words 0..PAY_WORDS-1 (ins_payload LSB first). All payload words are written before the header word, and the header word is the last write of the insert.
- R6: A successful insert gives exactly one cycle of cache_clr, in the same cycle as its res_valid. A failed insert gives none.
- R7: init_req, taken while idle, zeroes every word of the table, then pulses init_done and sets engine_en to 1.
- R8: When reserve_en is 1 at init, the header of every entry whose index mod 128 is 12, 25, 38, 51, 76, 89 or 102 is set to static (value 4). No insert ever picks such a slot. When reserve_en is 0 those entries are zero like all the others.
- R9: stop_req, taken while idle, writes 0 to every header, clears engine_en and then waits. It pulses stop_done with stop_timeout = 0 once engine_busy is low. If engine_busy stays high for busy_limit waiting cycles, it pulses stop_done with stop_timeout = 1. stop_timeout holds until the next stop.
- R10: ins_ready is low while an init, a stop or an insert is in progress. Init has priority over stop, and stop has priority over an insert request in the same cycle.
- R11: lk_ready is high only while idle with no init, stop or insert request present. A granted lookup returns lk_rvalid with the word at {lk_entry, lk_word} one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start table bring-up |
| reserve_en | input | 1 | Reserve the boundary-crossing slots at bring-up |
| init_done | output | 1 | Bring-up finished (pulse) |
| stop_req | input | 1 | Start table take-down |
| busy_limit | input | CNT_W | Maximum busy-wait cycles during take-down |
| engine_busy | input | 1 | Forwarding engine still active |
| stop_done | output | 1 | Take-down finished (pulse) |
| stop_timeout | output | 1 | Last take-down hit the busy limit |
| engine_en | output | 1 | Forwarding engine enable |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert accepted when high with ins_valid |
| ins_bucket | input | IDX_W | Precomputed bucket index |
| ins_hdr | input | W | Entry header word |
| ins_payload | input | PAY_WORDS*W | Entry payload words |
| ins_ts | input | TSIN_W | Insert timestamp |
| res_valid | output | 1 | Insert result (pulse) |
| res_ok | output | 1 | 1 = written, 0 = no space |
| res_slot | output | IDX_W | Slot that was written |
| cache_clr | output | 1 | Cache-clear strobe |
| lk_valid | input | 1 | Lookup read request |
| lk_ready | output | 1 | Lookup granted this cycle |
| lk_entry | input | IDX_W | Lookup entry index |
| lk_word | input | WSEL_W | Word within entry |
| lk_rvalid | output | 1 | Lookup data valid |
| lk_rdata | output | W | Lookup data |

## Verification
An insert and a lookup both want the single RAM port, and they can be requested in the same cycle. The bench raises ins_valid and lk_valid together at one edge. It expects the insert to be accepted and the lookup held back, and the lookup to be granted only after the insert result. The held lookup targets the slot being filled, so the data it returns must already be the new header. That shows the lookup was queued behind the insert's writes and did not slip in between them.

// File: rtl/flow_table_inserter.sv
`timescale 1ns/1ps
module flow_table_inserter #(
  parameter int ENTRIES   = 256,
  parameter int W         = 32,
  parameter int PAY_WORDS = 2,
  parameter int TS_W      = 8,
  parameter int TS_LSB    = 3,
  parameter int TSIN_W    = 16,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int WSEL_W   = $clog2(PAY_WORDS + 1),
  localparam int ADDR_W   = IDX_W + WSEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   init_req,
  input  logic                   reserve_en,
  output logic                   init_done,
  input  logic                   stop_req,
  input  logic [CNT_W-1:0]       busy_limit,
  input  logic                   engine_busy,
  output logic                   stop_done,
  output logic                   stop_timeout,
  output logic                   engine_en,
  input  logic                   ins_valid,
  output logic                   ins_ready,
  input  logic [IDX_W-1:0]       ins_bucket,
  input  logic [W-1:0]           ins_hdr,
  input  logic [PAY_WORDS*W-1:0] ins_payload,
  input  logic [TSIN_W-1:0]      ins_ts,
  output logic                   res_valid,
  output logic                   res_ok,
  output logic [IDX_W-1:0]       res_slot,
  output logic                   cache_clr,
  input  logic                   lk_valid,
  output logic                   lk_ready,
  input  logic [IDX_W-1:0]       lk_entry,
  input  logic [WSEL_W-1:0]      lk_word,
  output logic                   lk_rvalid,
  output logic [W-1:0]           lk_rdata
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int STATIC_BIT = 2;
  localparam logic [1:0] ST_BIND = 2'd2;
  localparam logic [W-1:0] TS_MASK    = {{(W-TS_W){1'b0}}, {TS_W{1'b1}}} << TS_LSB;
  localparam logic [W-1:0] STATIC_HDR = W'(1) << STATIC_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE0, S_CHK0, S_CHK1, S_WR, S_DONE, S_FAIL, S_INIT, S_STOP, S_WAIT
  } st_t;

  st_t                   st;
  logic [IDX_W-1:0]      bucket, slot;
  logic [W-1:0]          hdr_q;
  logic [PAY_WORDS*W-1:0] pay_q;
  logic [WSEL_W-1:0]     wc;
  logic [ADDR_W-1:0]     acnt;
  logic [CNT_W-1:0]      bcnt;
  logic                  reserve_q;
  logic                  ram_we;
  logic [ADDR_W-1:0]     ram_addr;
  logic [W-1:0]          ram_wd, ram_q;
  logic [W-1:0]          mem [DEPTH];
  logic [W-1:0]          words [PAY_WORDS+1];
  logic [W-1:0]          hdr_ts;
  logic                  idle_free;

  function automatic logic usable(input logic [W-1:0] h);
    return !h[STATIC_BIT] && (h[1:0] != ST_BIND);
  endfunction

  function automatic logic reserved(input logic [6:0] off);
    case (off)
      7'd12, 7'd25, 7'd38, 7'd51, 7'd76, 7'd89, 7'd102: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign hdr_ts    = (ins_hdr & ~TS_MASK) | ((W'(ins_ts) << TS_LSB) & TS_MASK);
  assign idle_free = (st == S_IDLE) && !init_req && !stop_req;
  assign ins_ready = idle_free;
  assign lk_ready  = idle_free && !ins_valid;
  assign res_valid = (st == S_DONE) || (st == S_FAIL);
  assign res_ok    = (st == S_DONE);
  assign cache_clr = (st == S_DONE);
  assign res_slot  = slot;
  assign lk_rdata  = ram_q;

  assign words[0] = hdr_q;
  for (genvar k = 1; k <= PAY_WORDS; k++) begin : g_pay
    assign words[k] = pay_q[(k-1)*W +: W];
  end

  always_comb begin
    ram_we   = 1'b0;
    ram_addr = {lk_entry, lk_word};
    ram_wd   = '0;
    case (st)
      S_PROBE0: ram_addr = {bucket, WSEL_W'(0)};
      S_CHK0:   ram_addr = {bucket + IDX_W'(1), WSEL_W'(0)};
      S_WR: begin
        ram_we   = 1'b1;
        ram_addr = {slot, wc};
        ram_wd   = words[wc];
      end
      S_INIT: begin
        ram_we   = 1'b1;
        ram_addr = acnt;
        if (reserve_q && acnt[WSEL_W-1:0] == '0 && reserved(acnt[WSEL_W +: 7]))
          ram_wd = STATIC_HDR;
      end
      S_STOP: begin
        ram_we   = 1'b1;
        ram_addr = {acnt[IDX_W-1:0], WSEL_W'(0)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wd;
    else        ram_q <= mem[ram_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      bucket       <= '0;
      slot         <= '0;
      hdr_q        <= '0;
      pay_q        <= '0;
      wc           <= '0;
      acnt         <= '0;
      bcnt         <= '0;
      reserve_q    <= 1'b0;
      engine_en    <= 1'b0;
      stop_timeout <= 1'b0;
      init_done    <= 1'b0;
      stop_done    <= 1'b0;
      lk_rvalid    <= 1'b0;
    end else begin
      init_done <= 1'b0;
      stop_done <= 1'b0;
      lk_rvalid <= lk_valid && lk_ready;
      case (st)
        S_IDLE: begin
          if (init_req) begin
            reserve_q <= reserve_en;
            acnt      <= '0;
            st        <= S_INIT;
          end else if (stop_req) begin
            acnt         <= '0;
            stop_timeout <= 1'b0;
            st           <= S_STOP;
          end else if (ins_valid) begin
            bucket <= ins_bucket;
            hdr_q  <= hdr_ts;
            pay_q  <= ins_payload;
            st     <= S_PROBE0;
          end
        end
        S_PROBE0: st <= S_CHK0;
        S_CHK0: begin
          if (usable(ram_q)) begin
            slot <= bucket;
            wc   <= WSEL_W'(PAY_WORDS);
            st   <= S_WR;
          end else begin
            st <= S_CHK1;
          end
        end
        S_CHK1: begin
          if (usable(ram_q)) begin
            slot <= bucket + IDX_W'(1);
            wc   <= WSEL_W'(PAY_WORDS);
            st   <= S_WR;
          end else begin
            slot <= bucket;
            st   <= S_FAIL;
          end
        end
        S_WR: begin
          if (wc == '0) st <= S_DONE;
          else          wc <= wc - WSEL_W'(1);
        end
        S_DONE, S_FAIL: st <= S_IDLE;
        S_INIT: begin
          acnt <= acnt + ADDR_W'(1);
          if (acnt == ADDR_W'(DEPTH - 1)) begin
            engine_en <= 1'b1;
            init_done <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_STOP: begin
          acnt <= acnt + ADDR_W'(1);
          if (acnt[IDX_W-1:0] == IDX_W'(ENTRIES - 1)) begin
            engine_en <= 1'b0;
            bcnt      <= '0;
            st        <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!engine_busy) begin
            stop_done <= 1'b1;
            st        <= S_IDLE;
          end else if (bcnt >= busy_limit) begin
            stop_done    <= 1'b1;
            stop_timeout <= 1'b1;
            st           <= S_IDLE;
          end else begin
            bcnt <= bcnt + CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_table_inserter_chk.sv
`timescale 1ns/1ps
module flow_table_inserter_chk #(
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [IDX_W-1:0]  ins_bucket,
  input logic              res_valid,
  input logic              res_ok,
  input logic [IDX_W-1:0]  res_slot,
  input logic              cache_clr,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              lk_rvalid,
  input logic              init_done,
  input logic              stop_done,
  input logic              stop_timeout,
  input logic              engine_en,
  input logic              engine_busy,
  input logic              ram_we,
  input logic [WSEL_W-1:0] ram_word
);
  logic [IDX_W-1:0] bucket_q;
  always_ff @(posedge clk) begin
    if (!rst_n) bucket_q <= '0;
    else if (ins_valid && ins_ready) bucket_q <= ins_bucket;
  end

  // R3
  slot_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> (res_slot == bucket_q || res_slot == bucket_q + IDX_W'(1)));
  // R4
  fail_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ok) |-> !$past(ram_we));
  // R5
  hdr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> ($past(ram_we && ram_word == '0) && $past(ram_we && ram_word != '0, 2)));
  // R6
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_clr |=> !cache_clr);
  // R7
  init_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> engine_en);
  // R9
  stop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> !engine_en);
  // R9
  stop_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && stop_timeout) |-> $past(engine_busy));
  // R10
  one_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> !ins_ready);
  // R11
  lk_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> lk_rvalid);
endmodule

bind flow_table_inserter flow_table_inserter_chk #(.IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_bucket(ins_bucket), .res_valid(res_valid), .res_ok(res_ok), .res_slot(res_slot),
  .cache_clr(cache_clr), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_rvalid(lk_rvalid),
  .init_done(init_done), .stop_done(stop_done), .stop_timeout(stop_timeout),
  .engine_en(engine_en), .engine_busy(engine_busy), .ram_we(ram_we),
  .ram_word(ram_addr[WSEL_W-1:0])
);

// File: tb/test_flow_table_inserter.sv
`timescale 1ns/1ps
module test_flow_table_inserter;
  localparam int N = 256;

  logic clk = 0, rst_n = 0;
  logic init_req = 0, reserve_en = 0, init_done;
  logic stop_req = 0, engine_busy = 0, stop_done, stop_timeout, engine_en;
  logic [15:0] busy_limit = 16'd5;
  logic ins_valid = 0, ins_ready;
  logic [7:0] ins_bucket = 0;
  logic [31:0] ins_hdr = 0;
  logic [63:0] ins_payload = 0;
  logic [15:0] ins_ts = 0;
  logic res_valid, res_ok, cache_clr;
  logic [7:0] res_slot;
  logic lk_valid = 0, lk_ready, lk_rvalid;
  logic [7:0] lk_entry = 0;
  logic [1:0] lk_word = 0;
  logic [31:0] lk_rdata;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mh [N];
  logic [63:0] mp [N];

  always #10 clk = ~clk;

  flow_table_inserter i_flow_table_inserter (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .reserve_en(reserve_en), .init_done(init_done),
    .stop_req(stop_req), .busy_limit(busy_limit), .engine_busy(engine_busy), .stop_done(stop_done),
    .stop_timeout(stop_timeout), .engine_en(engine_en), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_bucket(ins_bucket), .ins_hdr(ins_hdr), .ins_payload(ins_payload), .ins_ts(ins_ts),
    .res_valid(res_valid), .res_ok(res_ok), .res_slot(res_slot), .cache_clr(cache_clr),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_entry(lk_entry), .lk_word(lk_word),
    .lk_rvalid(lk_rvalid), .lk_rdata(lk_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit usable(input logic [31:0] h);
    return !h[2] && h[1:0] != 2'd2;
  endfunction

  function automatic bit rsv(input int i);
    int o = i % 128;
    return o == 12 || o == 25 || o == 38 || o == 51 || o == 76 || o == 89 || o == 102;
  endfunction

  task automatic lookup(input int e, input int w, output logic [31:0] d);
    @(negedge clk);
    lk_entry = 8'(e); lk_word = 2'(w); lk_valid = 1;
    for (int i = 0; i < 100 && !lk_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    d = lk_rdata;
    chk(lk_rvalid == 1'b1, "R11 rvalid", 64'(lk_rvalid), 1);
  endtask

  task automatic insert(input int b, input logic [31:0] h, input logic [63:0] p, input logic [15:0] ts,
                        output bit ok, output int slot);
    @(negedge clk);
    ins_bucket = 8'(b); ins_hdr = h; ins_payload = p; ins_ts = ts; ins_valid = 1;
    for (int i = 0; i < 100 && !ins_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0;
    chk(ins_ready == 1'b0, "R10 busy during insert", 64'(ins_ready), 0);
    for (int i = 0; i < 40 && !res_valid; i++) @(negedge clk);
    ok = res_ok; slot = int'(res_slot);
    chk(cache_clr == res_ok, "R6 strobe with result", 64'(cache_clr), 64'(res_ok));
    @(negedge clk);
    chk(cache_clr == 1'b0 && res_valid == 1'b0, "R6 single pulse", 64'(cache_clr), 0);
  endtask

  task automatic ins_model(input int b, input logic [31:0] h, input logic [63:0] p, input logic [15:0] ts,
                           input string req);
    bit ok, eok; int slot, es;
    logic [31:0] hw;
    hw = (h & ~32'h7F8) | ({16'h0, ts[7:0], 3'b0} & 32'h7F8);
    eok = 1; es = b;
    if (!usable(mh[b])) begin
      es = (b + 1) % N;
      if (!usable(mh[es])) eok = 0;
    end
    insert(b, h, p, ts, ok, slot);
    chk(ok == eok, {req, " ok"}, 64'(ok), 64'(eok));
    if (eok) begin
      chk(slot == es, {req, " slot"}, 64'(slot), 64'(es));
      mh[es] = hw; mp[es] = p;
    end
  endtask

  task automatic do_init(input bit r);
    @(negedge clk);
    init_req = 1; reserve_en = r;
    @(posedge clk);
    @(negedge clk);
    init_req = 0;
    chk(ins_ready == 0, "R10 busy during init", 64'(ins_ready), 0);
    for (int i = 0; i < 2000 && !init_done; i++) @(negedge clk);
    chk(init_done && engine_en, "R7 init done and enable", 64'({init_done, engine_en}), 3);
    for (int i = 0; i < N; i++) begin
      mh[i] = (r && rsv(i)) ? 32'h4 : 32'h0;
      mp[i] = 0;
    end
  endtask

  task automatic do_stop(input bit busy, input logic [15:0] lim);
    @(negedge clk);
    engine_busy = busy; busy_limit = lim; stop_req = 1;
    @(posedge clk);
    @(negedge clk);
    stop_req = 0;
    for (int i = 0; i < 2000 && !stop_done; i++) @(negedge clk);
    chk(stop_done == 1, "R9 stop done", 64'(stop_done), 1);
    chk(stop_timeout == busy, "R9 timeout flag", 64'(stop_timeout), 64'(busy));
    chk(engine_en == 0, "R9 engine disabled", 64'(engine_en), 0);
    engine_busy = 0;
    for (int i = 0; i < N; i++) mh[i] = 0;
  endtask

  initial begin
    logic [31:0] d;
    bit ok; int slot;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!engine_en && ins_ready && !res_valid && !cache_clr && !init_done && !stop_done,
        "R1 reset state", 64'({engine_en, ins_ready, res_valid, cache_clr}), 64'(4'b0100));

    do_init(1);
    lookup(12, 0, d);  chk(d == 32'h4, "R8 reserved header", d, 4);
    lookup(140, 0, d); chk(d == 32'h4, "R8 reserved second group", d, 4);
    lookup(13, 0, d);  chk(d == 32'h0, "R7 zeroed header", d, 0);
    lookup(13, 1, d);  chk(d == 32'h0, "R7 zeroed payload", d, 0);

    // R8 reserved slot skipped, R2 timestamp masking, R5 payload placement
    ins_model(12, 32'hFFFF_F802, 64'h1111_2222_3333_4444, 16'h12AB, "R8 skip reserved");
    lookup(13, 0, d); chk(d == 32'hFFFF_FD5A, "R2 header timestamp", d, 32'hFFFF_FD5A);
    lookup(13, 1, d); chk(d == 32'h3333_4444, "R5 payload word0", d, 32'h3333_4444);
    lookup(13, 2, d); chk(d == 32'h1111_2222, "R5 payload word1", d, 32'h1111_2222);

    // R4 bucket 11 then reserved 12: second insert has no space
    ins_model(11, 32'h2, 64'hAAAA, 16'h1, "R3 first probe");
    ins_model(11, 32'h2, 64'hBBBB, 16'h2, "R4 no space");
    lookup(11, 1, d); chk(d == 32'hAAAA, "R4 slot unchanged", d, 32'hAAAA);
    lookup(12, 0, d); chk(d == 32'h4, "R4 reserved untouched", d, 4);

    // R3 wrap to slot 0
    ins_model(255, 32'h2, 64'h55, 16'h3, "R3 wrap first");
    ins_model(255, 32'h2, 64'h66, 16'h4, "R3 wrap second");
    // R3 FIN and UNBIND slots are reusable
    ins_model(40, 32'h3, 64'h1, 16'h5, "R3 fin write");
    ins_model(40, 32'h1, 64'h2, 16'h6, "R3 fin overwrite");
    ins_model(40, 32'h2, 64'h3, 16'h7, "R3 unbind overwrite");

    // R11 insert and lookup in the same cycle
    @(negedge clk);
    ins_bucket = 8'd70; ins_hdr = 32'h2; ins_payload = 64'h77; ins_ts = 16'h9; ins_valid = 1;
    lk_entry = 8'd70; lk_word = 0; lk_valid = 1;
    #1;
    chk(ins_ready == 1 && lk_ready == 0, "R11 insert wins port", 64'({ins_ready, lk_ready}), 2);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0;
    ok = 0; slot = -1;
    for (int i = 0; i < 40 && !lk_ready; i++) begin
      if (res_valid) begin ok = res_ok; slot = int'(res_slot); end
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    chk(ok && slot == 70, "R3 concurrent insert slot", 64'(slot), 70);
    chk(lk_rvalid && lk_rdata == 32'h4A, "R11 held lookup sees new header", lk_rdata, 32'h4A);
    mh[70] = 32'h4A; mp[70] = 64'h77;

    // random inserts over a narrow bucket range to force collisions
    for (int n = 0; n < 300; n++) begin
      int b = int'($urandom % 24) + ((n % 3 == 0) ? 100 : 0);
      logic [31:0] h = $urandom;
      logic [63:0] p = {$urandom, $urandom};
      logic [15:0] ts = 16'($urandom);
      if (n % 4 != 0) h[2] = 0;
      ins_model(b, h, p, ts, "R3 random insert");
      if (n % 10 == 0) begin
        lookup(b, 0, d); chk(d == mh[b], "R2 random header", d, mh[b]);
        lookup(b, 1, d); chk(d == mp[b][31:0], "R5 random payload", d, mp[b][31:0]);
      end
    end

    // R9 stop, no busy
    do_stop(0, 16'd5);
    lookup(12, 0, d); chk(d == 0, "R9 header invalidated", d, 0);
    lookup(11, 0, d); chk(d == 0, "R9 bound header invalidated", d, 0);
    ins_model(11, 32'h2, 64'hC, 16'h1, "R9 slot free after stop");

    // R8 no reservation when option off
    do_init(0);
    lookup(12, 0, d); chk(d == 0, "R8 option off", d, 0);
    ins_model(12, 32'h2, 64'hD, 16'h1, "R8 option off slot");

    // R9 busy timeout
    do_stop(1, 16'd5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule